// File: doc/BRIEF.md
# GPIO Controller with Edge-Triggered Interrupts

This block is a 32-pin general-purpose I/O controller behind a simple word-wide register bus. Software decides for each pin whether it drives or receives. It also decides whether a driven pin pushes both levels or only pulls low (open-drain), and what value is latched for output. A read of the data register shows the driven value on output pins and the synchronized pad level on input pins. The pad cells sit outside the block, which exchanges plain output-value, output-enable and input vectors with them.

Every pin also has an edge detector. The bits of a control register select either falling edges only or edges in both directions. A detected edge sets a bit in a sticky event register, whatever the mask holds. Software clears event bits by writing ones to them. One interrupt line is high while any event bit is set whose mask bit is also set. Register bits are numbered from the top: pin n occupies bit 31 − n of every register.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Registers are addressed by byte offset: 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C event, 0x10 mask, 0x14 edge control. Pin n maps to bit 31 − n, so pin 0 is bit 31. After reset every register reads zero, irq is low and pad_oe is zero.
- R2: A direction bit of 1 makes the pin an output. A data read returns the latched value on bits whose direction is 1 and the synchronized pad level on bits whose direction is 0.
- R3: pad_out carries the data latch only where direction is 1. pad_oe is high where direction is 1, except where the open-drain bit is 1 and the latch holds 1, in which case the pin is released.
- R4: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged.
- R5: A detected edge sets its event bit whatever the mask holds. The bit is readable after the third rising clock edge that follows the pad change.
- R6: When an edge is detected in the same cycle as a write of 1 to that event bit, the bit stays set.
- R7: An edge-control bit of 1 detects falling edges only. A bit of 0 detects both rising and falling edges.
- R8: irq is high exactly while the bitwise AND of event and mask is non-zero. The mask resets to zero.
- R9: A read at any offset other than the six listed in R1 returns zero, including offsets that are not word-aligned.
- R10: A pad input passes through two flip-flops. A change becomes visible in the data read after the second rising clock edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wen | input | 1 | Write strobe, applied at the rising edge |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Value to drive on each pad |
| pad_oe | output | 32 | Drive enable for each pad |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is a clear-by-one that lands in the same cycle as a new edge on the same bit. The write has to arrive at exactly the clock edge where the edge has passed both synchronizer stages. The bench first sets the event bit with an earlier edge. It then toggles the pad and counts two rising edges, so the clear write is sampled on the third edge, the one that latches the new event. A lone clear with no edge follows right after, showing that the bit would otherwise have dropped.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int GPIO_PINS = 32;
  localparam int GPIO_AW   = 5;

  localparam logic [7:0] OFS_DIR = 8'h00;
  localparam logic [7:0] OFS_ODE = 8'h04;
  localparam logic [7:0] OFS_DAT = 8'h08;
  localparam logic [7:0] OFS_EVT = 8'h0C;
  localparam logic [7:0] OFS_MSK = 8'h10;
  localparam logic [7:0] OFS_CTL = 8'h14;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DIR, SEL_ODE, SEL_DAT, SEL_EVT, SEL_MSK, SEL_CTL
  } reg_sel_e;

  // One pin: did the synchronized level move in a way the pin listens for?
  function automatic logic edge_seen(logic prev, logic cur, logic fall_only);
    return (prev & ~cur) | (~prev & cur & ~fall_only);
  endfunction

  // One pin: value seen by a data read
  function automatic logic view_bit(logic is_out, logic latch, logic level);
    return is_out ? latch : level;
  endfunction

  // One pin: drive enable, open-drain releases a latched one
  function automatic logic drive_bit(logic is_out, logic od, logic latch);
    return is_out & ~(od & latch);
  endfunction
endpackage

// File: rtl/gpio_edge_dec.sv
module gpio_edge_dec
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W = GPIO_AW
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if      (addr == ADDR_W'(OFS_DIR)) sel = SEL_DIR;
    else if (addr == ADDR_W'(OFS_ODE)) sel = SEL_ODE;
    else if (addr == ADDR_W'(OFS_DAT)) sel = SEL_DAT;
    else if (addr == ADDR_W'(OFS_EVT)) sel = SEL_EVT;
    else if (addr == ADDR_W'(OFS_MSK)) sel = SEL_MSK;
    else if (addr == ADDR_W'(OFS_CTL)) sel = SEL_CTL;
    else                               sel = SEL_NONE;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
  import gpio_edge_pkg::*;
#(
  parameter int NPINS = GPIO_PINS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  input  logic [NPINS-1:0] fall_only,
  output logic [NPINS-1:0] sync_lvl,
  output logic [NPINS-1:0] edge_hit
);
  logic [NPINS-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_in;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign sync_lvl = lvl_q;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign edge_hit[p] = edge_seen(prev_q[p], lvl_q[p], fall_only[p]);
  end
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
  import gpio_edge_pkg::*;
#(
  parameter int NPINS = GPIO_PINS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] edge_hit,
  input  logic [NPINS-1:0] clr_mask,
  input  logic [NPINS-1:0] enable,
  output logic [NPINS-1:0] evt_q,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= (evt_q & ~clr_mask) | edge_hit;  // set beats clear
  end

  assign irq = |(evt_q & enable);
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NPINS  = GPIO_PINS,
  parameter int ADDR_W = GPIO_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq
);
  reg_sel_e         sel;
  logic [NPINS-1:0] dir_q, odr_q, dat_q, msk_q, ctl_q;
  logic [NPINS-1:0] sync_lvl, edge_hit, evt_q, evt_clr, data_view;

  gpio_edge_dec #(.ADDR_W(ADDR_W)) dec_i (.addr(bus_addr), .sel(sel));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      odr_q <= '0;
      dat_q <= '0;
      msk_q <= '0;
      ctl_q <= '0;
    end else if (bus_wen) begin
      unique case (sel)
        SEL_DIR: dir_q <= bus_wdata;
        SEL_ODE: odr_q <= bus_wdata;
        SEL_DAT: dat_q <= bus_wdata;
        SEL_MSK: msk_q <= bus_wdata;
        SEL_CTL: ctl_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign evt_clr = (bus_wen && sel == SEL_EVT) ? bus_wdata : '0;

  gpio_in_sync #(.NPINS(NPINS)) sync_i (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .fall_only(ctl_q),
    .sync_lvl(sync_lvl), .edge_hit(edge_hit)
  );

  gpio_evt_bank #(.NPINS(NPINS)) evt_i (
    .clk(clk), .rst_n(rst_n), .edge_hit(edge_hit), .clr_mask(evt_clr),
    .enable(msk_q), .evt_q(evt_q), .irq(irq)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pad
    assign pad_out[p]   = dir_q[p] & dat_q[p];
    assign pad_oe[p]    = drive_bit(dir_q[p], odr_q[p], dat_q[p]);
    assign data_view[p] = view_bit(dir_q[p], dat_q[p], sync_lvl[p]);
  end

  always_comb begin
    unique case (sel)
      SEL_DIR: bus_rdata = dir_q;
      SEL_ODE: bus_rdata = odr_q;
      SEL_DAT: bus_rdata = data_view;
      SEL_EVT: bus_rdata = evt_q;
      SEL_MSK: bus_rdata = msk_q;
      SEL_CTL: bus_rdata = ctl_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk
  import gpio_edge_pkg::*;
#(
  parameter int NPINS  = GPIO_PINS,
  parameter int ADDR_W = GPIO_AW
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wen,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  edge_hit,
  input logic [NPINS-1:0]  evt_q,
  input logic [NPINS-1:0]  msk_q,
  input logic [NPINS-1:0]  ctl_q,
  input logic [NPINS-1:0]  dir_q,
  input logic [NPINS-1:0]  odr_q,
  input logic [NPINS-1:0]  sync_lvl,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  pad_out,
  input logic              irq
);
  logic evt_wr;
  assign evt_wr = bus_wen && (bus_addr == ADDR_W'(OFS_EVT));

  AST_OE_ONLY_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~dir_q) == '0);  // R3
  AST_OD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & odr_q & pad_out) == '0);  // R3
  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wr |=> ((evt_q & $past(evt_q & ~bus_wdata)) == $past(evt_q & ~bus_wdata)));  // R4
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & ~$past(evt_q) & ~$past(edge_hit)) == '0));  // R5
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((evt_q & $past(edge_hit)) == $past(edge_hit)));  // R6
  AST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit & ctl_q & sync_lvl) == '0);  // R7
  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (!$stable(evt_q) || !$stable(msk_q)));  // R8
  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> (!$stable(evt_q) || !$stable(msk_q)));  // R8
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/gpio_edge_ctrl_tb_top.sv
module gpio_edge_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wen;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, pad_in, pad_out, pad_oe;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  gpio_edge_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  localparam logic [4:0] A_DIR = 5'h00, A_ODE = 5'h04, A_DAT = 5'h08,
                         A_EVT = 5'h0C, A_MSK = 5'h10, A_CTL = 5'h14;

  typedef struct packed {
    logic [31:0] dir, ode, dat, pin, exp_rd, exp_out, exp_oe;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{32'hFFFF0000, 32'h00000000, 32'h12345678, 32'h0000ABCD, 32'h1234ABCD, 32'h12340000, 32'hFFFF0000},
    '{32'h0000FFFF, 32'h00000000, 32'hAAAAAAAA, 32'h55555555, 32'h5555AAAA, 32'h0000AAAA, 32'h0000FFFF},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hF0F0F0F0, 32'h00000000, 32'hF0F0F0F0, 32'hF0F0F0F0, 32'h0F0F0F0F},
    '{32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hC3C3C3C3, 32'hC3C3C3C3, 32'h00000000, 32'h00000000},
    '{32'hFF00FF00, 32'hFFFFFFFF, 32'h0FF00FF0, 32'h12345678, 32'h0F340F78, 32'h0F000F00, 32'hF000F000}
  };

  function automatic logic [31:0] pin_mask(int pin);
    return 32'h80000000 >> pin;  // pin n is bit 31-n
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    step(1);
    bus_wen = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_wen = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset values
    foreach (VECS[i]) begin end
    for (int a = 0; a < 6; a++) begin
      rd(5'(a * 4), v);
      check("R1 reset register", v, 32'h0);
    end
    check("R1 reset irq", {31'b0, irq}, 32'h0);
    check("R1 reset pad_oe", pad_oe, 32'h0);

    // R2/R3 vector table
    for (int i = 0; i < 5; i++) begin
      wr(A_DIR, VECS[i].dir);
      wr(A_ODE, VECS[i].ode);
      wr(A_DAT, VECS[i].dat);
      pad_in = VECS[i].pin;
      step(3);
      rd(A_DAT, v);
      check("R2 data read", v, VECS[i].exp_rd);
      check("R3 pad_out", pad_out, VECS[i].exp_out);
      check("R3 pad_oe", pad_oe, VECS[i].exp_oe);
    end

    // R10 two-stage synchronizer latency
    wr(A_DIR, 32'h0);
    pad_in = 32'h0;
    step(3);
    pad_in = 32'h00FF00FF;
    rd(A_DAT, v);
    check("R10 no edge yet", v, 32'h0);
    step(1);
    rd(A_DAT, v);
    check("R10 after one edge", v, 32'h0);
    step(1);
    rd(A_DAT, v);
    check("R10 after two edges", v, 32'h00FF00FF);

    // clean slate for events
    pad_in = 32'h0;
    step(4);
    wr(A_EVT, 32'hFFFFFFFF);
    wr(A_CTL, 32'h0);
    wr(A_MSK, 32'h0);
    rd(A_EVT, v);
    check("R4 clear all", v, 32'h0);

    // R5 rise on pin 0 latches with mask zero, after third edge
    pad_in = pin_mask(0);
    step(2);
    rd(A_EVT, v);
    check("R5 not yet after two edges", v, 32'h0);
    step(1);
    rd(A_EVT, v);
    check("R5 latched regardless of mask", v, 32'h80000000);
    check("R8 masked off no irq", {31'b0, irq}, 32'h0);
    wr(A_MSK, 32'h80000000);
    check("R8 irq with mask", {31'b0, irq}, 32'h1);

    // R4 zeros keep, ones clear
    wr(A_EVT, 32'h7FFFFFFF);
    rd(A_EVT, v);
    check("R4 zero write keeps", v, 32'h80000000);
    check("R8 irq still high", {31'b0, irq}, 32'h1);
    wr(A_EVT, 32'h80000000);
    rd(A_EVT, v);
    check("R4 one write clears", v, 32'h0);
    check("R8 irq dropped", {31'b0, irq}, 32'h0);

    // R8 mask on a different pin, R7 falling with control 0
    wr(A_MSK, pin_mask(31));
    pad_in = 32'h0;
    step(3);
    rd(A_EVT, v);
    check("R7 both-edge mode sees fall", v, 32'h80000000);
    check("R8 other mask bit no irq", {31'b0, irq}, 32'h0);
    wr(A_EVT, 32'hFFFFFFFF);

    // R7 falling-only on pin 5
    wr(A_CTL, pin_mask(5));
    rd(A_CTL, v);
    check("R1 control readback pin5 bit26", v, 32'h04000000);
    pad_in = pin_mask(5);
    step(4);
    rd(A_EVT, v);
    check("R7 rise ignored in fall-only", v, 32'h0);
    pad_in = 32'h0;
    step(3);
    rd(A_EVT, v);
    check("R7 fall seen in fall-only", v, 32'h04000000);
    wr(A_EVT, 32'hFFFFFFFF);
    wr(A_CTL, 32'h0);

    // R6 clear collides with new edge on pin 3
    pad_in = pin_mask(3);
    step(3);
    rd(A_EVT, v);
    check("R6 preset event", v, 32'h10000000);
    pad_in = 32'h0;
    step(2);
    wr(A_EVT, pin_mask(3));
    rd(A_EVT, v);
    check("R6 edge wins over clear", v, 32'h10000000);
    wr(A_EVT, pin_mask(3));
    rd(A_EVT, v);
    check("R4 clear without edge", v, 32'h0);

    // R9 unmapped offsets
    rd(5'h18, v); check("R9 offset 0x18", v, 32'h0);
    rd(5'h1C, v); check("R9 offset 0x1C", v, 32'h0);
    wr(A_DIR, 32'hFFFFFFFF);
    rd(5'h02, v); check("R9 unaligned offset", v, 32'h0);

    finish_run();
  end
endmodule